// File: doc/BRIEF.md
# Watchdog-Guarded Bypass Relay Selector

This block drives one relay control level that chooses between a bypass path and a normal path. A seconds-scale watchdog runs beside the selector. Software keeps the watchdog alive by toggling a reload bit from 0 to 1 and back to 0. On each such toggle the countdown restarts with a period of 1, 2, 4 or 8 seconds, set by a 2-bit code. The code is taken from one of two code fields, and a source-select input chooses which field.

The relay level is set with a fixed priority:
1. Reset forces bypass.
2. An external header input forces bypass.
3. Otherwise a 2-bit bypass mode decides. One mode value hands the decision to the watchdog: the relay goes to bypass on expiry and stays there until a valid reload.

A sticky timeout flag reports the expiry. A parameterised prescaler turns the system clock into one tick per second.

Top module: `bwr_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its reset state. In that state the relay output is 1 (bypass), the timeout flag is 0, the countdown holds the 1-second period of code 00, and the prescaler restarts.
- R2: The timeout code sets the period in ticks: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. One tick is `TICK_DIV` clock cycles. After a reload, the flag rises exactly `TICK_DIV`×period edges later, with no reload in between.
- R3: Only a complete low-high-low sequence of the reload bit counts as a reload. The internal reload takes effect on the fourth clock edge after the bit is first sampled low again. A rising edge alone, or a level held high for any time, does not restart the countdown.
- R4: At a reload, the period code comes from `tmo_code_a_i` when `tmo_src_i` is 0 and from `tmo_code_b_i` when it is 1.
- R5: When the countdown reaches zero, the timeout flag goes to 1 and stays at 1 until a valid reload or a reset.
- R6: Bypass mode encoding, with the header inactive:
  - 00 gives normal (output 0).
  - 01 gives bypass (output 1).
  - 10 makes the output follow the timeout flag.
  - 11 gives normal.
  A timeout under modes 00 and 11 leaves the output at 0.
- R7: The header input goes through a two-stage synchroniser. When it is high, the output is 1 on the third edge, whatever the mode and the watchdog state.
- R8: Under mode 10, the output goes to 1 on the edge after the flag rises and holds there while the flag stays set. It returns to 0 on the edge after a reload clears the flag.
- R9: After reset is released, with no reload, the flag rises `TICK_DIV` edges after the last reset edge.
- R10: The relay output is registered. A change of mode shows at the output one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload_bit_i | input | 1 | Software reload bit; a 0-1-0 sequence reloads (asynchronous) |
| tmo_code_a_i | input | 2 | First timeout code field |
| tmo_code_b_i | input | 2 | Second timeout code field |
| tmo_src_i | input | 1 | Selects the code field used at a reload (0 = A, 1 = B) |
| bypass_mode_i | input | 2 | Bypass mode: 00 normal, 01 bypass, 10 watchdog-driven, 11 normal |
| hdr_force_i | input | 1 | External header input; high forces bypass (asynchronous) |
| relay_bypass_o | output | 1 | Relay control level: 1 bypass, 0 normal |
| wdt_expired_o | output | 1 | Sticky watchdog timeout flag |

## Verification
The hardest state to reach from the ports is the held-high reload bit. The bit goes high partway through a countdown and stays high past the expiry point. The bench must show that the period still runs out on the exact edge it would with no activity, and that releasing the bit then counts as one reload. The stimulus first does a clean reload so that the expiry edge is known. It then raises the bit a few ticks later and checks the flag on the edges either side of the expected expiry. It then checks the flag again after a long hold, and once more four edges after the bit falls.

// File: rtl/bwr_pkg.sv
// Package: shared types and helpers for the bypass relay watchdog.
// Assumes the countdown is wide enough for the longest period (8 ticks).
package bwr_pkg;

    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_BYPASS = 2'b01,
        MODE_WDOG   = 2'b10,
        MODE_RSVD   = 2'b11
    } relay_mode_e;

    // Number of one-second ticks for a 2-bit timeout code.
    function automatic logic [CNT_W-1:0] code_ticks(input logic [1:0] code);
        return CNT_W'(1) << code;
    endfunction

endpackage

// File: rtl/bwr_sync.sv
// Module: multi-stage synchroniser for a single asynchronous level.
// Assumes STAGES >= 2; the output lags the input by STAGES edges.
module bwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sync_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], d_i};
    end

    assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/bwr_reload_detect.sv
// Module: turns a complete 0-1-0 sequence of the software reload bit into a
// single-cycle pulse. A rising edge arms the detector; the following falling
// edge fires it. A level held high never fires repeatedly.
// Assumes the reload bit is asynchronous to clk.
module bwr_reload_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload_bit_i,
    output logic reload_o
);
    logic bit_s, prev_q, armed_q, pulse_q;
    logic rise, fall;

    bwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (reload_bit_i),
        .q_o   (bit_s)
    );

    assign rise = bit_s & ~prev_q;
    assign fall = ~bit_s & prev_q;

    // Track the previous level, the armed state and the output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= bit_s;
            pulse_q <= fall & armed_q;
            if (rise)      armed_q <= 1'b1;
            else if (fall) armed_q <= 1'b0;
        end
    end

    assign reload_o = pulse_q;

    // R3: one toggle gives exactly one single-cycle reload pulse.
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
endmodule

// File: rtl/bwr_tick_gen.sv
// Module: prescaler giving one tick every DIV clock cycles (one second at
// the system clock rate). A reload clears it so that periods start aligned.
// Assumes DIV >= 1.
module bwr_tick_gen #(
    parameter int DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Count clock cycles and wrap at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)   cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_chk
            // R2: ticks are isolated single-cycle pulses.
            p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/bwr_countdown.sv
// Module: watchdog countdown with sticky timeout flag. A reload loads the
// period of the selected code field and clears the flag; each tick
// decrements, and reaching zero sets the flag.
// Assumes reload and tick are single-cycle pulses.
module bwr_countdown
    import bwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       reload_i,
    input  logic [1:0] code_a_i,
    input  logic [1:0] code_b_i,
    input  logic       src_i,
    output logic       expired_o
);
    logic [CNT_W-1:0] count_q;
    logic             expired_q;
    logic [1:0]       code_sel;

    assign code_sel = src_i ? code_b_i : code_a_i;

    // Load on reload, decrement on tick, flag on reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= code_ticks(2'b00);
            expired_q <= 1'b0;
        end else if (reload_i) begin
            count_q   <= code_ticks(code_sel);
            expired_q <= 1'b0;
        end else if (tick_i && count_q != '0) begin
            count_q <= count_q - 1'b1;
            if (count_q == CNT_W'(1)) expired_q <= 1'b1;
        end
    end

    assign expired_o = expired_q;

    // R5: a reload always leaves the flag clear.
    p_reload_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> !expired_q);
    // R5: the flag is only set once the count has run out.
    p_zero_when_expired_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expired_q |-> (count_q == '0));
    // R2: the last tick of a period raises the flag.
    p_expire_on_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !reload_i && count_q == CNT_W'(1)) |=> expired_q);
endmodule

// File: rtl/bwr_relay_sel.sv
// Module: priority selector and output register for the relay level.
// Priority: reset, then header, then the mode (mode 10 follows the flag).
// Assumes the header input is already synchronised.
module bwr_relay_sel
    import bwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       hdr_i,
    input  logic       expired_i,
    output logic       relay_o
);
    logic relay_q, relay_d;
    relay_mode_e mode;

    assign mode = relay_mode_e'(mode_i);

    // Pick the next relay level by priority.
    always_comb begin
        if (hdr_i) relay_d = 1'b1;
        else begin
            case (mode)
                MODE_BYPASS: relay_d = 1'b1;
                MODE_WDOG:   relay_d = expired_i;
                default:     relay_d = 1'b0;
            endcase
        end
    end

    // Register the relay level; reset forces bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) relay_q <= 1'b1;
        else        relay_q <= relay_d;
    end

    assign relay_o = relay_q;

    // R1: reset forces bypass on the following edge.
    p_reset_bypass_r1: assert property (@(posedge clk)
        !rst_n |=> relay_q);
    // R7: the synchronised header forces bypass.
    p_hdr_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_i |=> relay_q);
    // R6: modes 00 and 11 give normal when the header is low.
    p_mode_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=> !relay_q);
    // R8: mode 10 follows the timeout flag.
    p_wdog_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hdr_i && mode_i == 2'b10) |=> (relay_q == $past(expired_i)));
endmodule

// File: rtl/bwr_top.sv
// Module: watchdog-guarded bypass relay selector (top level).
// Ties the reload detector, prescaler, countdown and relay selector together.
// Assumes reload_bit_i and hdr_force_i are asynchronous; all else synchronous.
module bwr_top #(
    parameter int TICK_DIV    = 50_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reload_bit_i,
    input  logic [1:0] tmo_code_a_i,
    input  logic [1:0] tmo_code_b_i,
    input  logic       tmo_src_i,
    input  logic [1:0] bypass_mode_i,
    input  logic       hdr_force_i,
    output logic       relay_bypass_o,
    output logic       wdt_expired_o
);
    logic reload_p, tick, expired, hdr_s;

    bwr_reload_detect #(.SYNC_STAGES(SYNC_STAGES)) u_reload (
        .clk          (clk),
        .rst_n        (rst_n),
        .reload_bit_i (reload_bit_i),
        .reload_o     (reload_p)
    );

    bwr_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (reload_p),
        .tick_o (tick)
    );

    bwr_countdown u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .reload_i  (reload_p),
        .code_a_i  (tmo_code_a_i),
        .code_b_i  (tmo_code_b_i),
        .src_i     (tmo_src_i),
        .expired_o (expired)
    );

    bwr_sync #(.STAGES(SYNC_STAGES)) u_hdr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (hdr_force_i),
        .q_o   (hdr_s)
    );

    bwr_relay_sel u_relay (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (bypass_mode_i),
        .hdr_i     (hdr_s),
        .expired_i (expired),
        .relay_o   (relay_bypass_o)
    );

    assign wdt_expired_o = expired;
endmodule

// File: tb/bwr_top_tb.sv
module bwr_top_tb;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reload_bit;
    logic [1:0] code_a, code_b;
    logic       src;
    logic [1:0] mode;
    logic       hdr;
    logic       relay, expired;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    bwr_top #(.TICK_DIV(DIV), .SYNC_STAGES(2)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reload_bit_i   (reload_bit),
        .tmo_code_a_i   (code_a),
        .tmo_code_b_i   (code_b),
        .tmo_src_i      (src),
        .bypass_mode_i  (mode),
        .hdr_force_i    (hdr),
        .relay_bypass_o (relay),
        .wdt_expired_o  (expired)
    );

    // Vector fields: {mode[1:0], header, expected relay}; watchdog not expired.
    localparam logic [3:0] VEC [8] = '{
        {2'b00, 1'b0, 1'b0}, {2'b01, 1'b0, 1'b1},
        {2'b10, 1'b0, 1'b0}, {2'b11, 1'b0, 1'b0},
        {2'b00, 1'b1, 1'b1}, {2'b01, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    // Complete 0-1-0 toggle; returns at the negedge where the bit drops.
    task automatic do_reload();
        reload_bit = 1'b1;
        repeat (4) @(negedge clk);
        reload_bit = 1'b0;
    endtask

    // Expiry lands exactly 4 + DIV*ticks edges after the drop.
    task automatic period_chk(input string tag, input logic s, input logic [1:0] a,
                              input logic [1:0] b, input int ticks);
        src = s; code_a = a; code_b = b;
        do_reload();
        edges(3 + DIV * ticks);
        chk(tag, expired, 1'b0);
        edges(1);
        chk(tag, expired, 1'b1);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reload_bit = 1'b0; code_a = 2'b00; code_b = 2'b00;
        src = 1'b0; mode = 2'b00; hdr = 1'b0;
        edges(3);
        chk("R1 reset relay", relay, 1'b1);
        chk("R1 reset flag", expired, 1'b0);

        // R9 / R10: release reset; relay drops next edge, flag after DIV edges.
        rst_n = 1'b1;
        edges(1);
        chk("R10 relay normal after release", relay, 1'b0);
        edges(DIV - 2);
        chk("R9 flag not yet", expired, 1'b0);
        edges(1);
        chk("R9 flag at default period", expired, 1'b1);
        edges(20);
        chk("R5 flag sticky", expired, 1'b1);
        chk("R6 mode 00 ignores timeout", relay, 1'b0);

        // Vector table walk: R6 mode encoding, R7 header force.
        code_a = 2'b11; src = 1'b0;
        for (int i = 0; i < 8; i++) begin
            do_reload();
            mode = VEC[i][3:2];
            hdr  = VEC[i][1];
            edges(6);
            chk($sformatf("R6/R7 vector %0d", i), relay, VEC[i][0]);
        end
        hdr = 1'b0; mode = 2'b00;
        edges(4);

        // R7 header latency: three edges.
        do_reload();
        edges(5);
        hdr = 1'b1;
        edges(2);
        chk("R7 header not before third edge", relay, 1'b0);
        edges(1);
        chk("R7 header third edge", relay, 1'b1);
        hdr = 1'b0;
        edges(4);

        // R10 mode latency: one edge.
        mode = 2'b01;
        edges(1);
        chk("R10 mode change one edge", relay, 1'b1);
        mode = 2'b00;
        edges(2);

        // R2 / R4: period per code and source select.
        period_chk("R2 code 00", 1'b0, 2'b00, 2'b11, 1);
        period_chk("R2 code 01", 1'b0, 2'b01, 2'b00, 2);
        period_chk("R2 code 10", 1'b0, 2'b10, 2'b00, 4);
        period_chk("R2 code 11", 1'b0, 2'b11, 2'b00, 8);
        period_chk("R4 source B 00", 1'b1, 2'b11, 2'b00, 1);
        period_chk("R4 source B 10", 1'b1, 2'b00, 2'b10, 4);

        // R8: mode 10 enters bypass after expiry and holds until reload.
        mode = 2'b10; src = 1'b0; code_a = 2'b00;
        do_reload();
        edges(4 + DIV);
        chk("R8 flag set", expired, 1'b1);
        chk("R8 relay one edge later (before)", relay, 1'b0);
        edges(1);
        chk("R8 relay bypass on expiry", relay, 1'b1);
        edges(30);
        chk("R8 bypass held", relay, 1'b1);
        do_reload();
        edges(4);
        chk("R5 reload clears flag", expired, 1'b0);
        chk("R8 relay still bypass", relay, 1'b1);
        edges(1);
        chk("R8 relay normal after reload", relay, 1'b0);
        mode = 2'b00;

        // R3: a held-high bit neither reloads nor repeats.
        code_a = 2'b01;
        do_reload();
        edges(8);
        reload_bit = 1'b1;
        edges(19 - 8);
        chk("R3 held high no reload (before)", expired, 1'b0);
        edges(1);
        chk("R3 held high no reload", expired, 1'b1);
        edges(40);
        chk("R3 level not repeating", expired, 1'b1);
        reload_bit = 1'b0;
        edges(3);
        chk("R3 falling edge not yet", expired, 1'b1);
        edges(1);
        chk("R3 completed toggle reloads", expired, 1'b0);

        // R1: reset mid-run with the flag set.
        edges(3 + 2 * DIV);
        chk("R5 flag before reset", expired, 1'b1);
        rst_n = 1'b0;
        edges(1);
        chk("R1 reset clears flag", expired, 1'b0);
        chk("R1 reset forces bypass", relay, 1'b1);
        rst_n = 1'b1;
        edges(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule